// File: doc/BRIEF.md
# Four-Byte Serial Programming Instruction Receiver

This block is the target-side front end of a serial programming link. A host drives a serial clock and a data line, and the block returns data on its own output line. Every instruction is exactly four bytes, sent most significant bit first. The block brings the serial clock and data into the system clock domain and detects clock edges there. It assembles each instruction and passes it to a command executor inside the chip. During the last byte of each frame it sends back the byte that the executor supplies.

The link starts locked. A frame whose first byte is 0xAC and whose second byte is 0x53 unlocks it. While the enable frame is being sent, the second byte comes back on the output line during the third byte. The host can read that echo to confirm that it is in step with the target. The frame always runs to its fourth byte, whether the enable was accepted or not. If the echo was wrong, the host raises `resync` for a few system clocks. This clears the frame position and locks the link again, so the host can retry.

The outputs toward the executor are single-cycle strobes with no back-pressure. The executor must take `hdr_valid` and `frame_valid` in the cycle they are high. After `hdr_valid` it answers with one `rd_valid` pulse, which must come before the serial clock falls at the end of the third byte. The `resync` input is synchronous to `clk`.

Top module: `prog_serial_front`

## Requirements
- R1: After `rst_n` is released, `miso` is 0, `prog_en` is 0, and neither strobe has fired.
- R2: `mosi` is sampled on rising `sck` edges, most significant bit first. `frame_data[31:24]` holds the first byte of the frame and `frame_data[7:0]` holds the fourth byte.
- R3: While unlocked, `frame_valid` is high for exactly one `clk` cycle after the 32nd rising edge of each frame, carrying the whole instruction.
- R4: A frame whose first byte is 0xAC and whose second byte is 0x53 sets `prog_en` once that frame completes. Any other frame leaves `prog_en` at 0. Once set, `prog_en` stays set until `resync`.
- R5: `miso` changes only after a falling `sck` edge. During the third byte of a frame, `miso` carries the second byte of the same frame, MSB first.
- R6: While `prog_en` is 0, no frame raises `hdr_valid` or `frame_valid`, and this includes the enable frame itself.
- R7: While unlocked, `hdr_valid` pulses for one cycle after the 24th rising edge, with the first three bytes on `hdr_data` (byte 1 in bits [23:16]). The byte captured on `rd_valid` is shifted out on `miso` during the fourth byte.
- R8: While `resync` is high, the frame position, the lock state and `miso` are all cleared. The next rising edge after `resync` starts a new frame at its first bit.
- R9: `miso` is 0x00 during bytes 1 and 2. It is also 0x00 during byte 4 when no `rd_valid` arrived after that frame's `hdr_valid`.
- R10: A rejected enable frame still uses up all 32 bits, so an enable frame sent right after it is decoded in alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resync | input | 1 | Synchronous clear of frame position and lock |
| sck | input | 1 | Serial clock from the host, asynchronous |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| prog_en | output | 1 | Link unlocked |
| hdr_valid | output | 1 | First three bytes ready (strobe) |
| hdr_data | output | 24 | First three bytes of the current frame |
| rd_valid | input | 1 | Read byte from the executor is valid |
| rd_data | input | 8 | Read byte to return in byte 4 |
| frame_valid | output | 1 | Full instruction ready (strobe) |
| frame_data | output | 32 | Assembled instruction |

## Verification
The receiver is driven with several kinds of frame:
- An ordinary command sent while the link is locked. This shows that the gate suppresses strobes but leaves the echo byte alone.
- An enable frame with a wrong key, followed at once by a correct one. This separates key checking from frame alignment.
- Asymmetric words such as 0xA5C30FF0. These expose bit reversal or byte swaps in `frame_data`.
- Commands sent with the executor answering and with it silent. These distinguish a returned byte from a stale one.
- A frame broken off part-way and then cleared by `resync`. This shows that the position counter and the lock really restart.

// File: rtl/prog_serial_pkg.sv
package prog_serial_pkg;
  localparam int BYTE_W      = 8;
  localparam int FRAME_BYTES = 4;
  localparam int FRAME_W     = BYTE_W * FRAME_BYTES;
  localparam int CNT_W       = $clog2(FRAME_W);
  localparam int LSB_W       = $clog2(BYTE_W);
  localparam int SLOT_W      = CNT_W - LSB_W;
  localparam int HDR_W       = FRAME_W - BYTE_W;
  localparam int ECHO_SLOT   = 2;
  localparam int READ_SLOT   = 3;
  localparam logic [BYTE_W-1:0] EN_OP  = 8'hAC;
  localparam logic [BYTE_W-1:0] EN_KEY = 8'h53;
  localparam logic [CNT_W-1:0]  HDR_LAST   = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0]  FRAME_LAST = CNT_W'(FRAME_W - 1);
endpackage

// File: rtl/prog_edge_sync.sv
module prog_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);
  logic [STAGES:0]   sck_p;
  logic [STAGES-1:0] mosi_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[STAGES-1:0], sck};
      mosi_p <= {mosi_p[STAGES-2:0], mosi};
    end
  end

  assign sck_rise = sck_p[STAGES-1] & ~sck_p[STAGES];
  assign sck_fall = ~sck_p[STAGES-1] & sck_p[STAGES];
  assign mosi_s   = mosi_p[STAGES-1];
endmodule

// File: rtl/prog_frame_rx.sv
module prog_frame_rx
  import prog_serial_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               resync,
  input  logic               sck_rise,
  input  logic               mosi_s,
  input  logic               rd_valid,
  input  logic [BYTE_W-1:0]  rd_data,
  output logic [CNT_W-1:0]   bit_cnt,
  output logic [BYTE_W-1:0]  echo_byte,
  output logic [BYTE_W-1:0]  rd_hold,
  output logic               prog_en,
  output logic               hdr_valid,
  output logic [HDR_W-1:0]   hdr_data,
  output logic               frame_valid,
  output logic [FRAME_W-1:0] frame_data
);
  logic [FRAME_W-1:0] rx_sr;
  logic [FRAME_W-1:0] word_next;
  logic               key_ok;

  assign word_next = {rx_sr[FRAME_W-2:0], mosi_s};
  assign key_ok    = (word_next[FRAME_W-1 -: BYTE_W] == EN_OP) &&
                     (word_next[HDR_W-1 -: BYTE_W] == EN_KEY);
  assign echo_byte = rx_sr[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr       <= '0;
      bit_cnt     <= '0;
      rd_hold     <= '0;
      prog_en     <= 1'b0;
      hdr_valid   <= 1'b0;
      hdr_data    <= '0;
      frame_valid <= 1'b0;
      frame_data  <= '0;
    end else if (resync) begin
      rx_sr       <= '0;
      bit_cnt     <= '0;
      rd_hold     <= '0;
      prog_en     <= 1'b0;
      hdr_valid   <= 1'b0;
      frame_valid <= 1'b0;
    end else begin
      hdr_valid   <= 1'b0;
      frame_valid <= 1'b0;
      if (rd_valid) rd_hold <= rd_data;
      if (sck_rise) begin
        rx_sr   <= word_next;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == HDR_LAST) begin
          hdr_valid <= prog_en;
          hdr_data  <= word_next[HDR_W-1:0];
          rd_hold   <= '0;
        end
        if (bit_cnt == FRAME_LAST) begin
          frame_valid <= prog_en;
          frame_data  <= word_next;
          if (!prog_en && key_ok) prog_en <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/prog_miso_tx.sv
module prog_miso_tx
  import prog_serial_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resync,
  input  logic              sck_fall,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic [BYTE_W-1:0] echo_byte,
  input  logic [BYTE_W-1:0] rd_hold,
  output logic              miso
);
  logic [BYTE_W-1:0] tx_sr;
  logic [SLOT_W-1:0] slot;
  logic              at_boundary;
  logic [BYTE_W-1:0] load_val;

  assign slot        = bit_cnt[CNT_W-1 -: SLOT_W];
  assign at_boundary = (bit_cnt[LSB_W-1:0] == '0);

  always_comb begin
    if (slot == SLOT_W'(ECHO_SLOT))      load_val = echo_byte;
    else if (slot == SLOT_W'(READ_SLOT)) load_val = rd_hold;
    else                                 load_val = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tx_sr <= '0;
    else if (resync)     tx_sr <= '0;
    else if (sck_fall) begin
      if (at_boundary)   tx_sr <= load_val;
      else               tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
    end
  end

  assign miso = tx_sr[BYTE_W-1];
endmodule

// File: rtl/prog_serial_front.sv
module prog_serial_front
  import prog_serial_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               resync,
  input  logic               sck,
  input  logic               mosi,
  output logic               miso,
  output logic               prog_en,
  output logic               hdr_valid,
  output logic [HDR_W-1:0]   hdr_data,
  input  logic               rd_valid,
  input  logic [BYTE_W-1:0]  rd_data,
  output logic               frame_valid,
  output logic [FRAME_W-1:0] frame_data
);
  logic              sck_rise;
  logic              sck_fall;
  logic              mosi_s;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] echo_byte;
  logic [BYTE_W-1:0] rd_hold;

  prog_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s)
  );

  prog_frame_rx rx_i (
    .clk(clk), .rst_n(rst_n), .resync(resync),
    .sck_rise(sck_rise), .mosi_s(mosi_s),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .bit_cnt(bit_cnt), .echo_byte(echo_byte), .rd_hold(rd_hold),
    .prog_en(prog_en), .hdr_valid(hdr_valid), .hdr_data(hdr_data),
    .frame_valid(frame_valid), .frame_data(frame_data)
  );

  prog_miso_tx tx_i (
    .clk(clk), .rst_n(rst_n), .resync(resync), .sck_fall(sck_fall),
    .bit_cnt(bit_cnt), .echo_byte(echo_byte), .rd_hold(rd_hold),
    .miso(miso)
  );
endmodule

// File: rtl/prog_serial_front_chk.sv
module prog_serial_front_chk (
  input logic clk,
  input logic rst_n,
  input logic resync,
  input logic sck_fall,
  input logic miso,
  input logic prog_en,
  input logic hdr_valid,
  input logic frame_valid
);
  a_r3_frame_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  a_r7_hdr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> !hdr_valid);

  a_r6_locked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |-> (!hdr_valid && !frame_valid));

  a_r4_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && !resync) |=> prog_en);

  a_r5_miso_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> ($past(sck_fall) || $past(resync)));

  a_r8_resync_clears: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (!prog_en && !miso && !frame_valid && !hdr_valid));
endmodule

bind prog_serial_front prog_serial_front_chk chk_i (
  .clk(clk), .rst_n(rst_n), .resync(resync), .sck_fall(sck_fall),
  .miso(miso), .prog_en(prog_en), .hdr_valid(hdr_valid),
  .frame_valid(frame_valid)
);

// File: tb/prog_serial_front_tb_top.sv
module prog_serial_front_tb_top;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        resync = 1'b0;
  logic        sck = 1'b0;
  logic        mosi = 1'b0;
  logic        miso;
  logic        prog_en;
  logic        hdr_valid;
  logic [23:0] hdr_data;
  logic        rd_valid = 1'b0;
  logic [7:0]  rd_data = 8'h00;
  logic        frame_valid;
  logic [31:0] frame_data;

  int checks = 0;
  int errors = 0;
  int fv_cnt = 0;
  int hv_cnt = 0;
  int wide_cnt = 0;
  bit exec_on = 1'b1;
  bit done = 1'b0;
  logic [23:0] last_hdr = '0;
  logic        fv_prev = 1'b0;

  always #5 clk = ~clk;

  prog_serial_front dut_i (
    .clk(clk), .rst_n(rst_n), .resync(resync), .sck(sck), .mosi(mosi),
    .miso(miso), .prog_en(prog_en), .hdr_valid(hdr_valid),
    .hdr_data(hdr_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .frame_valid(frame_valid), .frame_data(frame_data)
  );

  // Executor model: answers each header with a byte derived from it
  always @(posedge clk) begin
    rd_valid <= hdr_valid && exec_on;
    rd_data  <= hdr_data[7:0] ^ 8'h3C;
    if (hdr_valid) begin
      hv_cnt   <= hv_cnt + 1;
      last_hdr <= hdr_data;
    end
    if (frame_valid) fv_cnt <= fv_cnt + 1;
    if (frame_valid && fv_prev) wide_cnt <= wide_cnt + 1;
    fv_prev <= frame_valid;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] w, input int n,
                           output logic [31:0] back);
    back = '0;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      mosi = w[i];
      repeat (HALF) @(negedge clk);
      back[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic pulse_resync();
    @(negedge clk);
    resync = 1'b1;
    repeat (3) @(negedge clk);
    resync = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(miso == 1'b0, "R1 miso", {31'd0, miso}, 32'd0);
    chk(prog_en == 1'b0, "R1 prog_en", {31'd0, prog_en}, 32'd0);
    chk(fv_cnt == 0 && hv_cnt == 0, "R1 strobes", fv_cnt, 0);
  endtask

  task automatic t_locked();
    logic [31:0] b;
    int f0 = fv_cnt, h0 = hv_cnt;
    send_bits(32'h2012_3400, 32, b);
    chk(fv_cnt == f0 && hv_cnt == h0, "R6 no strobe while locked",
        fv_cnt - f0 + hv_cnt - h0, 0);
    chk(b == 32'h0000_1200, "R5 R9 echo while locked", b, 32'h0000_1200);
    chk(prog_en == 1'b0, "R4 stays locked", {31'd0, prog_en}, 32'd0);
  endtask

  task automatic t_enable();
    logic [31:0] b;
    int f0 = fv_cnt;
    send_bits(32'hAC00_0000, 32, b);
    chk(prog_en == 1'b0, "R4 wrong key rejected", {31'd0, prog_en}, 32'd0);
    chk(b == 32'h0, "R5 echo of wrong key", b, 32'h0);
    send_bits(32'hAC53_0000, 32, b);
    chk(prog_en == 1'b1, "R10 aligned enable after reject", {31'd0, prog_en}, 32'd1);
    chk(b == 32'h0000_5300, "R5 key echoed in byte 3", b, 32'h0000_5300);
    chk(fv_cnt == f0, "R6 enable frame not forwarded", fv_cnt - f0, 0);
  endtask

  task automatic t_cmd(input logic [31:0] w);
    logic [31:0] b;
    logic [31:0] exp_b;
    int f0 = fv_cnt, h0 = hv_cnt, w0 = wide_cnt;
    exp_b = {16'h0000, w[23:16], w[15:8] ^ 8'h3C};
    send_bits(w, 32, b);
    chk(fv_cnt == f0 + 1 && wide_cnt == w0, "R3 single frame strobe", fv_cnt - f0, 1);
    chk(frame_data == w, "R2 frame word", frame_data, w);
    chk(hv_cnt == h0 + 1 && last_hdr == w[31:8], "R7 header", {8'h0, last_hdr},
        {8'h0, w[31:8]});
    chk(b == exp_b, "R7 read byte on miso", b, exp_b);
  endtask

  task automatic t_no_resp();
    logic [31:0] b;
    exec_on = 1'b0;
    send_bits(32'h4000_1099, 32, b);
    chk(b == 32'h0000_0000, "R9 byte 4 without response", b, 32'h0);
    exec_on = 1'b1;
  endtask

  task automatic t_resync();
    logic [31:0] b;
    int f0;
    send_bits(32'h0000_1FFF, 13, b);
    pulse_resync();
    chk(prog_en == 1'b0, "R8 lock cleared", {31'd0, prog_en}, 32'd0);
    chk(miso == 1'b0, "R8 miso cleared", {31'd0, miso}, 32'd0);
    f0 = fv_cnt;
    send_bits(32'h2801_7E00, 32, b);
    chk(fv_cnt == f0, "R8 locked after resync", fv_cnt - f0, 0);
    send_bits(32'hAC53_1122, 32, b);
    chk(prog_en == 1'b1 && b == 32'h0000_5300, "R8 realigned enable", b, 32'h0000_5300);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_locked();
    t_enable();
    t_cmd(32'h2801_7E00);
    t_cmd(32'hA5C3_0FF0);
    t_no_resp();
    t_resync();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule